// File: doc/BRIEF.md
# Static RAM Window Decoder for a 20-bit Memory Bus

This block places a 128 KB static RAM, built from four 32 KB devices, into a 1 MB memory address space. A four-bit base setting, held static like a bank of switches, picks the 64 KB bank where the window starts. The window covers that bank and the one above it, so it can begin on any bank boundary, odd or even. Typical placements are banks 0–1, banks 8–9, and banks D–E in the upper area.

The decoder has no clock. It qualifies the active-low read and write strobes. A cycle is serviced only when exactly one of them is low. For such a cycle it drives one of four active-low device selects, gated output-enable and write-enable lines shared by the devices, and the fifteen low address bits. It also raises a read-hit flag, which turns the bus data buffer toward the bus.

Top module: `sram_window_decoder`

## Requirements
- R1: The bus bank is address bits 19..16. A cycle hits the window when (bank − base) mod 16 equals 0, or equals 1 with base not equal to 15.
- R2: On a hit, the selected device index is {low bit of (bank − base), address bit 15}. Index 0 is the lowest 32 KB of the window, and device k drives `ramCsN[k]` low.
- R3: At most one bit of `ramCsN` is low at any time.
- R4: When both strobes are low or both are high, every bit of `ramCsN` is high, and `ramOeN`, `ramWeN` and `rdHit` are inactive.
- R5: `ramAddr` always equals bus address bits 14..0.
- R6: `ramOeN` is low only on a hit with the read strobe alone low. `ramWeN` is low only on a hit with the write strobe alone low.
- R7: `rdHit` is 1 only on a read cycle that hits the window. It is 0 on any write, any miss and any invalid strobe pair.
- R8: With base 15, bank 0 never hits. The window does not wrap past the top of memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busAddr | input | 20 | Bus memory address |
| memRdN | input | 1 | Bus memory read strobe, active low |
| memWrN | input | 1 | Bus memory write strobe, active low |
| baseBank | input | 4 | Static window base bank number |
| ramCsN | output | 4 | Per-device chip selects, active low |
| ramOeN | output | 1 | Shared RAM output enable, active low |
| ramWeN | output | 1 | Shared RAM write enable, active low |
| ramAddr | output | 15 | Address bits for the RAM devices |
| rdHit | output | 1 | Read hit; turns the data buffer toward the bus |

## Verification
The checker examines the relations among the outputs whenever an input changes:
- at most one device selected;
- no select, enable or read hit on an invalid strobe pair;
- the address passed through unchanged;
- a read hit always paired with a selected device and a low output enable;
- write enable never low together with a read hit.

Only the bench scenarios can show which device a given bank and base pick, including the wrap case at base 15. They sweep every base against every bank, every strobe pair and both halves of each bank, and compare each cycle with a window model computed from absolute addresses.

// File: rtl/sram_window_pkg.sv
package sram_window_pkg;
  // Qualified strobes passed from control to datapath
  typedef struct packed {
    logic cycleOk;   // exactly one strobe active
    logic isRead;
    logic isWrite;
  } winStrobes_t;
endpackage

// File: rtl/sram_win_ctrl.sv
module sram_win_ctrl
  import sram_window_pkg::*;
(
  input  logic        memRdN,
  input  logic        memWrN,
  output winStrobes_t strobes
);
  logic rdAct;
  logic wrAct;

  always_comb begin
    rdAct = ~memRdN;
    wrAct = ~memWrN;
    strobes.cycleOk = rdAct ^ wrAct;
    strobes.isRead  = rdAct & ~wrAct;
    strobes.isWrite = wrAct & ~rdAct;
  end
endmodule

// File: rtl/sram_win_dp.sv
module sram_win_dp
  import sram_window_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int BANK_W     = 4,
  parameter int DEV_ADDR_W = 15,
  parameter int NUM_DEV    = 4
) (
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [BANK_W-1:0]     baseBank,
  input  winStrobes_t           strobes,
  output logic [NUM_DEV-1:0]    ramCsN,
  output logic                  ramOeN,
  output logic                  ramWeN,
  output logic [DEV_ADDR_W-1:0] ramAddr,
  output logic                  rdHit
);
  localparam int IDX_W = $clog2(NUM_DEV);
  localparam logic [BANK_W-1:0] TOP_BANK = '1;

  logic [BANK_W-1:0] busBank;
  logic [BANK_W-1:0] bankOfs;
  logic              inWindow;
  logic              hit;
  logic [IDX_W-1:0]  devIdx;

  always_comb begin
    busBank  = busAddr[ADDR_W-1 -: BANK_W];
    bankOfs  = busBank - baseBank;
    inWindow = (bankOfs == '0) ||
               ((bankOfs == BANK_W'(1)) && (baseBank != TOP_BANK));
    hit      = inWindow & strobes.cycleOk;
    devIdx   = {bankOfs[0], busAddr[DEV_ADDR_W]};
    ramAddr  = busAddr[DEV_ADDR_W-1:0];
    ramOeN   = ~(hit & strobes.isRead);
    ramWeN   = ~(hit & strobes.isWrite);
    rdHit    = hit & strobes.isRead;
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_sel
    assign ramCsN[d] = ~(hit && (devIdx == IDX_W'(d)));
  end
endmodule

// File: rtl/sram_window_decoder.sv
module sram_window_decoder
  import sram_window_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int BANK_W     = 4,
  parameter int DEV_ADDR_W = 15,
  parameter int NUM_DEV    = 4
) (
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  memRdN,
  input  logic                  memWrN,
  input  logic [BANK_W-1:0]     baseBank,
  output logic [NUM_DEV-1:0]    ramCsN,
  output logic                  ramOeN,
  output logic                  ramWeN,
  output logic [DEV_ADDR_W-1:0] ramAddr,
  output logic                  rdHit
);
  winStrobes_t strobes;

  sram_win_ctrl u_ctrl (
    .memRdN (memRdN),
    .memWrN (memWrN),
    .strobes(strobes)
  );

  sram_win_dp #(
    .ADDR_W    (ADDR_W),
    .BANK_W    (BANK_W),
    .DEV_ADDR_W(DEV_ADDR_W),
    .NUM_DEV   (NUM_DEV)
  ) u_dp (
    .busAddr (busAddr),
    .baseBank(baseBank),
    .strobes (strobes),
    .ramCsN  (ramCsN),
    .ramOeN  (ramOeN),
    .ramWeN  (ramWeN),
    .ramAddr (ramAddr),
    .rdHit   (rdHit)
  );
endmodule

// File: rtl/sram_window_chk.sv
module sram_window_chk #(
  parameter int ADDR_W     = 20,
  parameter int DEV_ADDR_W = 15,
  parameter int NUM_DEV    = 4
) (
  input logic [ADDR_W-1:0]     busAddr,
  input logic                  memRdN,
  input logic                  memWrN,
  input logic [NUM_DEV-1:0]    ramCsN,
  input logic                  ramOeN,
  input logic                  ramWeN,
  input logic [DEV_ADDR_W-1:0] ramAddr,
  input logic                  rdHit
);
  always_comb begin
    // R3
    one_dev_chk: assert ($countones(~ramCsN) <= 1);
    // R4
    if (memRdN == memWrN)
      bad_strobe_idle_chk: assert (&ramCsN && ramOeN && ramWeN && !rdHit);
    // R5
    addr_pass_chk: assert (ramAddr == busAddr[DEV_ADDR_W-1:0]);
    // R7
    if (rdHit)
      rd_hit_sel_chk: assert (!ramOeN && !memRdN && memWrN && !(&ramCsN));
    // R6
    no_rd_wr_chk: assert (ramWeN || rdHit == 1'b0);
  end
endmodule

bind sram_window_decoder sram_window_chk #(
  .ADDR_W(ADDR_W), .DEV_ADDR_W(DEV_ADDR_W), .NUM_DEV(NUM_DEV)
) u_chk (
  .busAddr(busAddr), .memRdN(memRdN), .memWrN(memWrN),
  .ramCsN(ramCsN), .ramOeN(ramOeN), .ramWeN(ramWeN),
  .ramAddr(ramAddr), .rdHit(rdHit)
);

// File: tb/sram_window_decoder_tb.sv
module sram_window_decoder_tb;
  logic        clk = 1'b0;
  logic [19:0] busAddr = '0;
  logic        memRdN = 1'b1;
  logic        memWrN = 1'b1;
  logic [3:0]  baseBank = '0;
  logic [3:0]  ramCsN;
  logic        ramOeN, ramWeN, rdHit;
  logic [14:0] ramAddr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [3:0]  csN;
    logic        oeN;
    logic        weN;
    logic [14:0] addr;
    logic        rdHit;
    string       tag;
  } expItem_t;

  expItem_t sbQ[$];

  always #2.5 clk = ~clk;  // 200 MHz

  sram_window_decoder u_dut (
    .busAddr(busAddr), .memRdN(memRdN), .memWrN(memWrN), .baseBank(baseBank),
    .ramCsN(ramCsN), .ramOeN(ramOeN), .ramWeN(ramWeN), .ramAddr(ramAddr),
    .rdHit(rdHit)
  );

  // Reference model: absolute window start and end, no modulo arithmetic
  task automatic drive(input logic [19:0] a, input logic rdN, input logic wrN,
                       input logic [3:0] base);
    expItem_t e;
    int start, idx;
    bit valid, isRd, isWr, hit;
    @(posedge clk);
    busAddr = a; memRdN = rdN; memWrN = wrN; baseBank = base;
    start = int'(base) * 65536;
    valid = (rdN != wrN);
    isRd  = valid && !rdN;
    isWr  = valid && !wrN;
    hit   = valid && (int'(a) >= start) && (int'(a) < start + 131072);
    idx   = (int'(a) - start) / 32768;
    e.csN   = 4'hF;
    if (hit) e.csN[idx] = 1'b0;
    e.oeN   = !(hit && isRd);
    e.weN   = !(hit && isWr);
    e.addr  = a[14:0];
    e.rdHit = hit && isRd;
    if (!valid)                          e.tag = "R4";
    else if (base == 4'hF && a[19:16] == 4'h0) e.tag = "R8";
    else                                 e.tag = "R1/R2";
    sbQ.push_back(e);
  endtask

  task automatic cmp(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: compare away from the driving edge
  always @(negedge clk) begin
    if (sbQ.size() > 0) begin
      expItem_t e;
      e = sbQ.pop_front();
      cmp(e.tag, "ramCsN", 32'(ramCsN), 32'(e.csN));
      cmp("R3", "selected count", 32'($countones(~ramCsN)),
          32'($countones(~e.csN)));
      cmp("R6", "ramOeN", 32'(ramOeN), 32'(e.oeN));
      cmp("R6", "ramWeN", 32'(ramWeN), 32'(e.weN));
      cmp("R5", "ramAddr", 32'(ramAddr), 32'(e.addr));
      cmp("R7", "rdHit", 32'(rdHit), 32'(e.rdHit));
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [19:0] a;
    // Idle state: no strobes, nothing selected (R4)
    #1;
    cmp("R4", "idle ramCsN", 32'(ramCsN), 32'hF);
    cmp("R7", "idle rdHit", 32'(rdHit), 32'h0);
    // Full sweep
    for (int b = 0; b < 16; b++)
      for (int k = 0; k < 16; k++)
        for (int s = 0; s < 4; s++)
          for (int h = 0; h < 2; h++) begin
            a = {4'(k), 1'(h), 15'((b * 977 + k * 131 + s * 4099 + h) & 16'h7FFF)};
            drive(a, s[0], s[1], 4'(b));
          end
    // Named placements: banks 0-1, 8-9, D-E, top edges (R1, R2, R8)
    drive(20'h1FFFF, 1'b0, 1'b1, 4'h0);
    drive(20'h80000, 1'b1, 1'b0, 4'h8);
    drive(20'hEFFFF, 1'b0, 1'b1, 4'hD);
    drive(20'hF0000, 1'b0, 1'b1, 4'hD);
    drive(20'h0FFFF, 1'b0, 1'b1, 4'hF);
    drive(20'hFFFFF, 1'b1, 1'b0, 4'hF);
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule